// File: doc/BRIEF.md
# Packet Staging Engine

This block carries one endpoint packet between system memory, reached through a byte-wide bus-master port, and an endpoint FIFO. All data passes through a 64-byte staging buffer. A load (memory to FIFO) fetches up to one buffer of bytes over the bus, gives the bus back, and then copies those bytes into the FIFO. An unload (FIFO to memory) first fills the buffer from the FIFO, then takes the bus and writes the bytes out. In both directions the round repeats until the whole packet has moved.

The bus is held only while bytes flow between the buffer and memory. A pause input freezes the FIFO side for as long as a register slave access lasts. An error response on the bus ends the packet at once. Completion is reported on a one-cycle pulse that carries an error flag and the number of bytes delivered to the destination. A separate address sequencer loads the start address and steps it by one for each completed bus beat.

The controller has five states. **ST_IDLE** accepts a command. **ST_BUS_WAIT** raises the bus request and waits for grant. **ST_BUS_MOVE** runs one bus beat per granted, answered cycle. **ST_FIFO_MOVE** runs one FIFO byte per ready cycle. **ST_REPORT** drives the done pulse. The transitions are:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_REPORT | zero-length command |
| ST_IDLE | ST_BUS_WAIT | load command |
| ST_IDLE | ST_FIFO_MOVE | unload command |
| ST_BUS_WAIT | ST_BUS_MOVE | grant |
| ST_BUS_MOVE | ST_REPORT | error response, or last beat of the final unload chunk |
| ST_BUS_MOVE | ST_FIFO_MOVE | last beat of a load chunk, or last beat of an unload chunk when bytes remain |
| ST_FIFO_MOVE | ST_BUS_WAIT | last byte of an unload chunk, or last byte of a load chunk when bytes remain |
| ST_FIFO_MOVE | ST_REPORT | last byte of the final load chunk |
| ST_REPORT | ST_IDLE | always |

Top module: `pktmv_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `fifo_wr`, `fifo_rd` and `done` are all 0.
- R2: A load requests the bus first. Once granted, it reads bytes at consecutive addresses from `cmd_addr`, one per cycle where `bus_valid` and `bus_ack` are both 1. It releases `bus_req` after min(remaining, 64) beats.
- R3: After each bus release on a load, the buffered bytes go into the FIFO in address order. The rounds repeat until the FIFO has received exactly `cmd_len` bytes, which equal memory from `cmd_addr` upward.
- R4: An unload first reads min(remaining, 64) bytes from the FIFO. `bus_req` stays 0 until that fill is complete.
- R5: An unload writes each filled chunk to consecutive addresses from `cmd_addr` (`bus_write`=1). Fill and write rounds repeat until `cmd_len` bytes are in memory in FIFO order. With a 130-byte packet, the bus tenures carry 64, 64 and 2 beats.
- R6: `bus_req` is never 1 in a cycle in which `fifo_wr` or `fifo_rd` is 1.
- R7: The FIFO side moves one byte per cycle when the FIFO is ready. It never writes while `fifo_full`=1 and never reads while `fifo_empty`=1, and stalls lose or repeat no byte.
- R8: While `pause`=1, `fifo_wr` and `fifo_rd` are both 0, and the transfer continues unchanged once `pause` falls.
- R9: A beat answered with `bus_err`=1 ends the transfer. In the next cycle `bus_req` is 0 and `done` is 1 with `done_err`=1. No further bus beat is made. `done_count` counts only bytes delivered to the destination.
- R10: `done` is a single-cycle pulse with `done_count` equal to `cmd_len` on success. A zero-length command completes with count 0 and no bus or FIFO activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start a packet (taken when `cmd_ready`) |
| cmd_unload | input | 1 | 1: FIFO to memory, 0: memory to FIFO |
| cmd_addr | input | ADDR_W | Memory start byte address |
| cmd_len | input | LEN_W | Packet length in bytes |
| cmd_ready | output | 1 | Engine idle |
| bus_req | output | 1 | Bus mastership request |
| bus_gnt | input | 1 | Bus mastership granted |
| bus_valid | output | 1 | Beat offered this cycle |
| bus_write | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W | Beat byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data |
| bus_ack | input | 1 | Beat completed |
| bus_err | input | 1 | Beat failed |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 8 | FIFO write data |
| fifo_full | input | 1 | FIFO cannot accept |
| fifo_rd | output | 1 | FIFO read strobe |
| fifo_rdata | input | 8 | FIFO head byte (show-ahead) |
| fifo_empty | input | 1 | FIFO has no byte |
| pause | input | 1 | Register slave access in progress |
| done | output | 1 | Packet finished (one cycle) |
| done_err | output | 1 | Finished on bus error |
| done_count | output | LEN_W | Bytes delivered |

## Verification
If the chunk counter or the byte index goes wrong, the bus tenures change length, and the bench sees this at the first bus release of the packet. Bytes from the buffer also arrive at the FIFO or in memory in the wrong order or at the wrong address. A wrong direction or phase state shows up in the same cycle, as a bus request together with a FIFO strobe. A bad stall or pause gate shows up in the same cycle as a strobe while the FIFO is not ready. A fault in error handling or the remaining-length count shows up in the single cycle of the done pulse, as a wrong count or flag, or as a pulse that never comes.

// File: rtl/pktmv_pkg.sv
package pktmv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_WAIT,
        ST_BUS_MOVE,
        ST_FIFO_MOVE,
        ST_REPORT
    } mv_state_t;
endpackage

// File: rtl/pktmv_stage_buf.sv
module pktmv_stage_buf #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[idx[IDX_W-2:0]] <= wr_data;
    end

    assign rd_data = cells[idx[IDX_W-2:0]];

    // The index never leaves the buffer while a byte is stored (R2).
    assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/pktmv_addr_seq.sv
module pktmv_addr_seq #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= start_addr;
        else if (step) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/pktmv_ctrl.sv
module pktmv_ctrl
    import pktmv_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_unload,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             cmd_ready,
    output logic             bus_req,
    input  logic             bus_gnt,
    output logic             bus_valid,
    output logic             bus_write,
    input  logic             bus_ack,
    input  logic             bus_err,
    output logic             fifo_wr,
    input  logic             fifo_full,
    output logic             fifo_rd,
    input  logic             fifo_empty,
    input  logic             pause,
    output logic             buf_we,
    output logic [IDX_W-1:0] buf_idx,
    output logic             addr_load,
    output logic             addr_step,
    output logic             done,
    output logic             done_err,
    output logic [LEN_W-1:0] done_count
);
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(DEPTH);

    mv_state_t        state, state_nx;
    logic             unload_q;
    logic             err_q;
    logic [LEN_W-1:0] remaining;
    logic [LEN_W-1:0] moved;
    logic [IDX_W-1:0] chunk;
    logic [IDX_W-1:0] idx;

    logic             accept;
    logic             beat_ok;
    logic             beat_bad;
    logic             fifo_go;
    logic             step;
    logic             last;
    logic             new_chunk;
    logic [LEN_W-1:0] rem_src;
    logic [IDX_W-1:0] chunk_sz;

    // Handshake decode
    always_comb begin
        accept   = (state == ST_IDLE) && cmd_valid;
        beat_bad = (state == ST_BUS_MOVE) && bus_gnt && bus_err;
        beat_ok  = (state == ST_BUS_MOVE) && bus_gnt && bus_ack && !bus_err;
        fifo_go  = (state == ST_FIFO_MOVE) && !pause &&
                   (unload_q ? !fifo_empty : !fifo_full);
        step     = beat_ok || fifo_go;
        last     = step && (IDX_W'(idx + 1'b1) == chunk);
        rem_src  = accept ? cmd_len : remaining;
        chunk_sz = (rem_src > DEPTH_L) ? DEPTH_I : rem_src[IDX_W-1:0];
        new_chunk = accept ||
                    (last && (remaining != '0) &&
                     (((state == ST_FIFO_MOVE) && !unload_q) ||
                      ((state == ST_BUS_MOVE) && unload_q)));
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_len == '0)   state_nx = ST_REPORT;
                    else if (cmd_unload) state_nx = ST_FIFO_MOVE;
                    else                 state_nx = ST_BUS_WAIT;
                end
            end
            ST_BUS_WAIT: begin
                if (bus_gnt) state_nx = ST_BUS_MOVE;
            end
            ST_BUS_MOVE: begin
                if (beat_bad) state_nx = ST_REPORT;
                else if (last) begin
                    if (!unload_q)             state_nx = ST_FIFO_MOVE;
                    else if (remaining == '0)  state_nx = ST_REPORT;
                    else                       state_nx = ST_FIFO_MOVE;
                end
            end
            ST_FIFO_MOVE: begin
                if (last) begin
                    if (unload_q)              state_nx = ST_BUS_WAIT;
                    else if (remaining == '0)  state_nx = ST_REPORT;
                    else                       state_nx = ST_BUS_WAIT;
                end
            end
            ST_REPORT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unload_q  <= 1'b0;
            err_q     <= 1'b0;
            remaining <= '0;
            moved     <= '0;
            chunk     <= '0;
            idx       <= '0;
        end else begin
            if (accept) begin
                unload_q <= cmd_unload;
                err_q    <= 1'b0;
            end else if (beat_bad) begin
                err_q    <= 1'b1;
            end

            if (new_chunk) begin
                chunk     <= chunk_sz;
                remaining <= rem_src - LEN_W'(chunk_sz);
            end

            if (accept || last) idx <= '0;
            else if (step)      idx <= idx + 1'b1;

            if (accept) moved <= '0;
            else if ((fifo_go && !unload_q) || (beat_ok && unload_q))
                moved <= moved + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        bus_req    = (state == ST_BUS_WAIT) || (state == ST_BUS_MOVE);
        bus_valid  = (state == ST_BUS_MOVE) && bus_gnt;
        bus_write  = unload_q;
        fifo_wr    = fifo_go && !unload_q;
        fifo_rd    = fifo_go && unload_q;
        buf_we     = (beat_ok && !unload_q) || (fifo_go && unload_q);
        buf_idx    = idx;
        addr_load  = accept;
        addr_step  = beat_ok;
        done       = (state == ST_REPORT);
        done_err   = err_q;
        done_count = moved;
    end

    // A FIFO move never runs past the current chunk (R7).
    assert_fifo_within_chunk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIFO_MOVE) |-> (idx < chunk));

    // An unload never holds the bus before its chunk is staged (R4).
    assert_fill_before_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_BUS_WAIT) && unload_q) |-> (idx == '0));
endmodule

// File: rtl/pktmv_engine.sv
module pktmv_engine #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_unload,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic              fifo_wr,
    output logic [7:0]        fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_rd,
    input  logic [7:0]        fifo_rdata,
    input  logic              fifo_empty,
    input  logic              pause,
    output logic              done,
    output logic              done_err,
    output logic [LEN_W-1:0]  done_count
);
    localparam int IDX_W = $clog2(DEPTH) + 1;

    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;
    logic [7:0]       buf_rd;
    logic             addr_load;
    logic             addr_step;

    pktmv_ctrl #(.LEN_W(LEN_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_unload (cmd_unload),
        .cmd_len    (cmd_len),
        .cmd_ready  (cmd_ready),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .fifo_wr    (fifo_wr),
        .fifo_full  (fifo_full),
        .fifo_rd    (fifo_rd),
        .fifo_empty (fifo_empty),
        .pause      (pause),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .done       (done),
        .done_err   (done_err),
        .done_count (done_count)
    );

    pktmv_stage_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .idx     (buf_idx),
        .wr_data (bus_write ? fifo_rdata : bus_rdata),
        .rd_data (buf_rd)
    );

    pktmv_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (addr_load),
        .start_addr (cmd_addr),
        .step       (addr_step),
        .addr       (bus_addr)
    );

    assign bus_wdata  = buf_rd;
    assign fifo_wdata = buf_rd;

    assert_bus_fifo_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !(fifo_wr || fifo_rd));

    assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);

    assert_no_read_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> !fifo_rd);

    assert_pause_freezes_fifo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> !(fifo_wr || fifo_rd));

    assert_error_ends_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_err) |=> (done && done_err && !bus_req));

    assert_done_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_pktmv_engine.sv
`timescale 1ns/1ps
module sim_pktmv_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_unload = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic        cmd_ready, bus_req, bus_valid, bus_write;
    logic        bus_gnt = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata = '0;
    logic        fifo_wr, fifo_rd, fifo_full = 1'b0, fifo_empty = 1'b1;
    logic [7:0]  fifo_wdata, fifo_rdata = '0;
    logic        pause = 1'b0;
    logic        done, done_err;
    logic [15:0] done_count;

    always #2.5 clk = ~clk;

    pktmv_engine u0 (.*);

    int n_chk = 0, n_fail = 0;
    logic [7:0] rmem [1024];
    logic [7:0] wmem [1024];
    logic [7:0] src  [256];
    logic [7:0] sink [256];
    int sink_n, src_ptr, src_len, beat_n, err_at, cyc_n;
    int ten [8];
    int ten_n, cur_ten, first_req_src;
    logic prev_req;
    int done_n, last_count, fw_first, fw_last;
    logic last_err;
    int v_excl, v_pause, v_full, v_empty;
    logic stall_en = 1'b0, pause_en = 1'b0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Memory, bus and FIFO responders, acting between clock edges
    always begin
        @(negedge clk);
        bus_gnt = bus_req;
        #1;
        cyc_n++;
        fifo_full  = stall_en && (cyc_n % 3 == 0);
        fifo_empty = (src_ptr >= src_len) || (stall_en && (cyc_n % 4 == 0));
        fifo_rdata = src[src_ptr[7:0]];
        pause      = pause_en && (cyc_n % 5 < 2);
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (bus_valid) begin
            beat_n++;
            if (beat_n == err_at) bus_err = 1'b1;
            else begin
                bus_ack   = 1'b1;
                bus_rdata = rmem[bus_addr[9:0]];
            end
        end
        #1;
        if (fifo_wr) begin
            sink[sink_n[7:0]] = fifo_wdata;
            sink_n++;
            if (fw_first < 0) fw_first = cyc_n;
            fw_last = cyc_n;
        end
        if (fifo_rd) src_ptr++;
        if (bus_valid && bus_ack && bus_write) wmem[bus_addr[9:0]] = bus_wdata;
        if (bus_valid && bus_ack) cur_ten++;
        if (bus_req && !prev_req && first_req_src < 0) first_req_src = src_ptr;
        if (!bus_req && prev_req) begin
            if (ten_n < 8) ten[ten_n] = cur_ten;
            ten_n++;
            cur_ten = 0;
        end
        prev_req = bus_req;
        if (bus_req && (fifo_wr || fifo_rd)) v_excl++;
        if (pause && (fifo_wr || fifo_rd)) v_pause++;
        if (fifo_full && fifo_wr) v_full++;
        if (fifo_empty && fifo_rd) v_empty++;
        if (done) begin
            done_n++;
            last_count = done_count;
            last_err   = done_err;
        end
    end

    task automatic clear_run(int slen);
        sink_n = 0; src_ptr = 0; src_len = slen; beat_n = 0; err_at = 0;
        ten_n = 0; cur_ten = 0; first_req_src = -1; done_n = 0;
        fw_first = -1; fw_last = -1;
        v_excl = 0; v_pause = 0; v_full = 0; v_empty = 0;
        for (int i = 0; i < 1024; i++) wmem[i] = 8'hEE;
    endtask

    task automatic run_cmd(logic unl, int addr, int len);
        int guard;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_unload = unl; cmd_addr = addr; cmd_len = 16'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (done_n == 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        chk("R1 ready", int'(cmd_ready), 1);
        chk("R1 idle strobes", int'({bus_req, fifo_wr, fifo_rd, done}), 0);
    endtask

    task automatic t_short_load;
        int bad = 0;
        clear_run(0);
        run_cmd(1'b0, 32'h100, 10);
        for (int i = 0; i < 10; i++) if (sink[i] != rmem[10'h100 + i]) bad++;
        chk("R3 short load data", bad, 0);
        chk("R3 short load bytes", sink_n, 10);
        chk("R2 short load tenures", ten_n, 1);
        chk("R2 short load beats", ten[0], 10);
        chk("R7 one byte per cycle", fw_last - fw_first + 1, 10);
        chk("R10 done once", done_n, 1);
        chk("R10 short load count", last_count, 10);
        chk("R6 exclusion", v_excl, 0);
    endtask

    task automatic t_long_load_stalls;
        int bad = 0;
        clear_run(0);
        stall_en = 1'b1; pause_en = 1'b1;
        run_cmd(1'b0, 32'h200, 150);
        stall_en = 1'b0; pause_en = 1'b0;
        for (int i = 0; i < 150; i++) if (sink[i] != rmem[10'h200 + i]) bad++;
        chk("R3 long load data", bad, 0);
        chk("R7 long load bytes", sink_n, 150);
        chk("R2 long load tenures", ten_n, 3);
        chk("R2 chunk sizes", ten[0] * 10000 + ten[1] * 100 + ten[2], 646422);
        chk("R7 no write while full", v_full, 0);
        chk("R8 no strobe while paused", v_pause, 0);
        chk("R6 exclusion with stalls", v_excl, 0);
        chk("R10 long load count", last_count, 150);
        chk("R10 long load flag", int'(last_err), 0);
    endtask

    task automatic t_unload(int len, int addr, int exp_tens);
        int bad = 0;
        clear_run(len);
        stall_en = 1'b1; pause_en = 1'b1;
        run_cmd(1'b1, addr, len);
        stall_en = 1'b0; pause_en = 1'b0;
        for (int i = 0; i < len; i++) if (wmem[addr + i] != src[i]) bad++;
        chk("R5 unload data", bad, 0);
        chk("R5 unload tail untouched", int'(wmem[addr + len]), 8'hEE);
        chk("R4 fill before bus", first_req_src, len > 64 ? 64 : len);
        chk("R5 unload tenures", ten_n, exp_tens);
        chk("R7 no read while empty", v_empty, 0);
        chk("R8 unload pause", v_pause, 0);
        chk("R6 unload exclusion", v_excl, 0);
        chk("R10 unload count", last_count, len);
        if (len == 130) chk("R5 tenure sizes", ten[0] * 10000 + ten[1] * 100 + ten[2], 646402);
    endtask

    task automatic t_zero;
        clear_run(0);
        run_cmd(1'b0, 32'h40, 0);
        chk("R10 zero done", done_n, 1);
        chk("R10 zero count", last_count, 0);
        chk("R10 zero no bus", ten_n, 0);
        chk("R10 zero no fifo", sink_n, 0);
    endtask

    task automatic t_err_load;
        clear_run(0);
        err_at = 70;
        run_cmd(1'b0, 32'h200, 150);
        chk("R9 load err flag", int'(last_err), 1);
        chk("R9 load err count", last_count, 64);
        chk("R9 load err fifo bytes", sink_n, 64);
        chk("R9 load err no more beats", beat_n, 70);
        chk("R9 bus released", int'(bus_req), 0);
    endtask

    task automatic t_err_unload;
        clear_run(20);
        err_at = 6;
        run_cmd(1'b1, 32'h300, 20);
        chk("R9 unload err flag", int'(last_err), 1);
        chk("R9 unload err count", last_count, 5);
        chk("R9 unload err mem", int'(wmem[10'h305]), 8'hEE);
        chk("R9 unload err beats", beat_n, 6);
        chk("R10 ready again", int'(cmd_ready), 1);
    endtask

    initial begin
        #(150000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) rmem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 256; i++) src[i] = 8'(i * 13 + 5);
        cyc_n = 0; prev_req = 1'b0;
        clear_run(0);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_short_load;
        t_long_load_stalls;
        t_unload(130, 32'h100, 3);
        t_unload(64, 32'h180, 1);
        t_zero;
        t_err_load;
        t_err_unload;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule